// File: doc/BRIEF.md
# Bus Transaction Timeout Watchdog

This block guards the bus operations of several independent channels. Each channel tells the block when one of its operations begins (a one-cycle start pulse) and when it completes (a one-cycle done pulse). If the completion does not arrive within a programmed time, the channel's timeout flag goes high. The flag stays high until the channel's bit is written in a one-to-clear mask.

The time limit has two stages. A coarse prescaler divides the block clock by one of three powers of two, or the timeout is switched off. A tick counter then waits for a power-of-two number of prescaled ticks, from 4 to 512. Each channel samples its own configuration when its operation starts. The count always begins from zero at the start pulse, and it holds while no operation is pending.

Top module: `bus_op_timeout_guard`

## Requirements
- R1: While reset is asserted, and right after it is released, every timeout flag is 0 and no operation is pending.
- R2: The 2-bit scale field of a channel selects the prescale divisor D. Value 0 means the timeout is off. Values 1, 2 and 3 select 2^SHIFT_LO, 2^SHIFT_MID and 2^SHIFT_HI respectively (default exponents 8, 16 and 24).
- R3: The 3-bit tick field t selects a tick count N = 4·2^t, which gives 4, 8, 16, 32, 64, 128, 256 or 512 prescaled ticks.
- R4: Suppose a clock edge samples a start pulse and neither start nor done is sampled afterwards. The flag then becomes 1 exactly at the D·N-th rising edge after that edge, and not earlier.
- R5: A done pulse sampled at or before the expiry edge cancels the pending operation. The flag is not set, and the channel stays idle afterwards.
- R6: When the sampled scale field is 0, the flag never sets, whatever the tick field holds and however long the operation stays pending.
- R7: A start pulse that arrives while an operation is pending restarts both stages from zero. Expiry is then counted from the new start.
- R8: The scale and tick fields are sampled only on the start edge. Changing them while an operation is pending does not alter its timeout.
- R9: The flag is sticky. A later done pulse does not clear it, and only the channel's clear-mask bit does. When an expiry and a clear happen on the same edge, the flag ends up set.
- R10: Channels are independent. A clear-mask bit, a start pulse or a done pulse affects only the channel it belongs to.
- R11: A done pulse with no pending operation has no effect. After an expiry the channel is idle, so the flag does not set again without a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scale_sel_i | input | 2·NUM_CH | Per-channel prescale selection, channel c in bits [2c+1:2c] |
| tick_sel_i | input | 3·NUM_CH | Per-channel tick count selection, channel c in bits [3c+2:3c] |
| op_start_i | input | NUM_CH | One-cycle pulse per channel: an operation begins |
| op_done_i | input | NUM_CH | One-cycle pulse per channel: the operation completed |
| flag_clr_i | input | NUM_CH | Write-one-to-clear mask for the timeout flags |
| timeout_flag_o | output | NUM_CH | Sticky per-channel timeout flag |

## Verification
The only output is the flag, so a wrong internal state shows up as a flag edge in the wrong cycle or as a missing flag. A prescaler or tick counter that is off by one moves the rising edge of the flag by one prescaled tick or by one clock. A missed restart or a wrong configuration sample moves it by a whole interval. For these reasons the flag of each channel is compared against a behavioural model on every clock. The bench uses small prescale exponents so that the longest setting finishes inside the run. A pending state that leaks after a cancel, or a lost sticky bit, shows as a flag that differs from the model within one interval of the event.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

  typedef enum logic [1:0] {
    SCALE_OFF = 2'd0,
    SCALE_LO  = 2'd1,
    SCALE_MID = 2'd2,
    SCALE_HI  = 2'd3
  } scale_e;

  localparam int TSEL_W    = 3;
  localparam int TICK_BASE = 4;
  localparam int TSEL_MAX  = (1 << TSEL_W) - 1;
  localparam int TICK_MAX  = TICK_BASE << TSEL_MAX;

endpackage

// File: rtl/tmo_prescaler.sv
module tmo_prescaler
  import tmo_pkg::*;
#(
  parameter int SHIFT_LO  = 8,
  parameter int SHIFT_MID = 16,
  parameter int SHIFT_HI  = 24
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   run_i,
  input  scale_e scale_i,
  output logic   tick_o
);

  localparam int SW = SHIFT_HI;
  localparam logic [SW-1:0] ONES     = {SW{1'b1}};
  localparam logic [SW-1:0] MASK_LO  = ONES >> (SW - SHIFT_LO);
  localparam logic [SW-1:0] MASK_MID = ONES >> (SW - SHIFT_MID);
  localparam logic [SW-1:0] MASK_HI  = ONES;

  logic [SW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] mask;
  logic          en;

  always_comb begin
    unique case (scale_i)
      SCALE_LO:  mask = MASK_LO;
      SCALE_MID: mask = MASK_MID;
      SCALE_HI:  mask = MASK_HI;
      default:   mask = '0;
    endcase
  end

  assign en     = run_i && (scale_i != SCALE_OFF);
  assign tick_o = en && ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)   cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || en)      cnt_q <= cnt_d;
  end

  AST_PRE_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/tmo_tick_counter.sv
module tmo_tick_counter
  import tmo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [TSEL_W-1:0] sel_i,
  output logic              last_o
);

  localparam int CW = $clog2(TICK_MAX);
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};
  localparam logic [TSEL_W-1:0] SEL_TOP = TSEL_W'(TSEL_MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = CNT_TOP >> (SEL_TOP - sel_i);
  assign last_o = tick_i && (cnt_q == lim_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (last_o) cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_i)   cnt_q <= cnt_d;
  end

  AST_TCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(sel_i) |-> (cnt_q <= lim_m1)); // R3

endmodule

// File: rtl/tmo_channel.sv
module tmo_channel
  import tmo_pkg::*;
#(
  parameter int SHIFT_LO  = 8,
  parameter int SHIFT_MID = 16,
  parameter int SHIFT_HI  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        scale_i,
  input  logic [TSEL_W-1:0] tsel_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              clr_i,
  output logic              flag_o
);

  logic              busy_q, busy_d;
  logic              flag_q, flag_d;
  scale_e            scale_q;
  logic [TSEL_W-1:0] tsel_q;
  logic              pre_tick;
  logic              tick_last;
  logic              expire;

  tmo_prescaler #(
    .SHIFT_LO (SHIFT_LO),
    .SHIFT_MID(SHIFT_MID),
    .SHIFT_HI (SHIFT_HI)
  ) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .run_i  (busy_q),
    .scale_i(scale_q),
    .tick_o (pre_tick)
  );

  tmo_tick_counter i_tcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_i),
    .tick_i(pre_tick),
    .sel_i (tsel_q),
    .last_o(tick_last)
  );

  assign expire = busy_q && tick_last && !done_i && !start_i;

  always_comb begin
    busy_d = busy_q;
    if (start_i)               busy_d = 1'b1;
    else if (done_i || expire) busy_d = 1'b0;
  end

  always_comb begin
    flag_d = flag_q;
    if (expire)     flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q <= SCALE_OFF;
      tsel_q  <= '0;
    end else if (start_i) begin
      scale_q <= scale_e'(scale_i);
      tsel_q  <= tsel_i;
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R9

  AST_OFF_NEVER_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(scale_q) != SCALE_OFF)); // R6

  AST_SET_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(busy_q)); // R4

  AST_DONE_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i && !start_i && !flag_q) |=> (!busy_q && !flag_q)); // R5

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(scale_q) && $stable(tsel_q))); // R8

endmodule

// File: rtl/bus_op_timeout_guard.sv
module bus_op_timeout_guard
  import tmo_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int SHIFT_LO  = 8,
  parameter int SHIFT_MID = 16,
  parameter int SHIFT_HI  = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2*NUM_CH-1:0]      scale_sel_i,
  input  logic [TSEL_W*NUM_CH-1:0] tick_sel_i,
  input  logic [NUM_CH-1:0]        op_start_i,
  input  logic [NUM_CH-1:0]        op_done_i,
  input  logic [NUM_CH-1:0]        flag_clr_i,
  output logic [NUM_CH-1:0]        timeout_flag_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmo_channel #(
      .SHIFT_LO (SHIFT_LO),
      .SHIFT_MID(SHIFT_MID),
      .SHIFT_HI (SHIFT_HI)
    ) i_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .scale_i(scale_sel_i[2*c +: 2]),
      .tsel_i (tick_sel_i[TSEL_W*c +: TSEL_W]),
      .start_i(op_start_i[c]),
      .done_i (op_done_i[c]),
      .clr_i  (flag_clr_i[c]),
      .flag_o (timeout_flag_o[c])
    );
  end

  AST_CLR_ONLY_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i == '0) |=> ((timeout_flag_o & ~$past(timeout_flag_o)) == timeout_flag_o
                           || $past(timeout_flag_o) == (timeout_flag_o & $past(timeout_flag_o)))); // R10

endmodule

// File: tb/test_bus_op_timeout_guard.sv
`timescale 1ns/1ps
module test_bus_op_timeout_guard;

  localparam int NCH = 2;
  localparam int LO  = 2;
  localparam int MID = 4;
  localparam int HI  = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [2*NCH-1:0] scale;
  logic [3*NCH-1:0] tsel;
  logic [NCH-1:0] start, done, clr;
  logic [NCH-1:0] flag;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  int m_busy [NCH];
  int m_el   [NCH];
  int m_lim  [NCH];
  bit m_flag [NCH];

  always #2.5 clk = ~clk;

  bus_op_timeout_guard #(
    .NUM_CH(NCH), .SHIFT_LO(LO), .SHIFT_MID(MID), .SHIFT_HI(HI)
  ) i_bus_op_timeout_guard (
    .clk_i(clk), .rst_ni(rst_n), .scale_sel_i(scale), .tick_sel_i(tsel),
    .op_start_i(start), .op_done_i(done), .flag_clr_i(clr), .timeout_flag_o(flag)
  );

  function automatic int limit_of(int s, int t);
    int d;
    case (s)
      1: d = 1 << LO;
      2: d = 1 << MID;
      3: d = 1 << HI;
      default: d = 0;
    endcase
    return d * (4 << t);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_busy[c] = 0; m_el[c] = 0; m_lim[c] = 0; m_flag[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit set_now;
        set_now = 0;
        if (start[c]) begin
          m_busy[c] = 1; m_el[c] = 0;
          m_lim[c] = limit_of(int'(scale[2*c +: 2]), int'(tsel[3*c +: 3]));
        end else if (done[c]) begin
          m_busy[c] = 0;
        end else if (m_busy[c] != 0) begin
          m_el[c]++;
          if (m_lim[c] != 0 && m_el[c] == m_lim[c]) begin
            set_now = 1; m_busy[c] = 0;
          end
        end
        if (set_now) m_flag[c] = 1;
        else if (clr[c]) m_flag[c] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) chk({cur_req, " model"}, flag[c], m_flag[c]);
    end
  end

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic go(logic [NCH-1:0] m);
    start = m; @(negedge clk); start = '0;
  endtask
  task automatic fin(logic [NCH-1:0] m);
    done = m; @(negedge clk); done = '0;
  endtask
  task automatic wipe(logic [NCH-1:0] m);
    clr = m; @(negedge clk); clr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scale = '0; tsel = '0; start = '0; done = '0; clr = '0;
    waitn(3);
    chk("R1", flag[0], 1'b0);
    chk("R1", flag[1], 1'b0);
    rst_n = 1'b1;
    waitn(2);
    chk("R1", flag[0], 1'b0);

    // R4: scale 1, tick 0 -> 4*4 = 16 cycles
    cur_req = "R4";
    scale[1:0] = 2'd1; tsel[2:0] = 3'd0;
    go(2'b01); waitn(15);
    chk("R4", flag[0], 1'b0);
    waitn(1);
    chk("R4", flag[0], 1'b1);
    wipe(2'b01);
    chk("R9", flag[0], 1'b0);

    // R2: mid scale, tick 3 -> 16*32 = 512
    cur_req = "R2";
    scale[3:2] = 2'd2; tsel[5:3] = 3'd3;
    go(2'b10); waitn(511);
    chk("R2", flag[1], 1'b0);
    waitn(1);
    chk("R2", flag[1], 1'b1);
    wipe(2'b10);

    // R3: high scale, tick 7 -> 64*512 = 32768
    cur_req = "R3";
    scale[1:0] = 2'd3; tsel[2:0] = 3'd7;
    go(2'b01); waitn(32767);
    chk("R3", flag[0], 1'b0);
    waitn(1);
    chk("R3", flag[0], 1'b1);
    wipe(2'b01);

    // R5: done on the expiry edge, then early done
    cur_req = "R5";
    scale[1:0] = 2'd1; tsel[2:0] = 3'd1;
    go(2'b01); waitn(31); fin(2'b01);
    chk("R5", flag[0], 1'b0);
    waitn(100);
    chk("R5", flag[0], 1'b0);
    go(2'b01); waitn(5); fin(2'b01); waitn(60);
    chk("R5", flag[0], 1'b0);

    // R6: scale off with longest tick field
    cur_req = "R6";
    scale[3:2] = 2'd0; tsel[5:3] = 3'd7;
    go(2'b10); waitn(3000);
    chk("R6", flag[1], 1'b0);
    fin(2'b10);

    // R7: restart while pending
    cur_req = "R7";
    scale[1:0] = 2'd1; tsel[2:0] = 3'd0;
    go(2'b01); waitn(10); go(2'b01); waitn(15);
    chk("R7", flag[0], 1'b0);
    waitn(1);
    chk("R7", flag[0], 1'b1);
    wipe(2'b01);

    // R8: config change while pending is ignored
    cur_req = "R8";
    go(2'b01); waitn(2);
    scale[1:0] = 2'd3; tsel[2:0] = 3'd7;
    waitn(13);
    chk("R8", flag[0], 1'b0);
    waitn(1);
    chk("R8", flag[0], 1'b1);
    wipe(2'b01);

    // R9: sticky through late done, set wins over clear
    cur_req = "R9";
    scale[1:0] = 2'd1; tsel[2:0] = 3'd0;
    go(2'b01); waitn(16);
    fin(2'b01); waitn(5);
    chk("R9", flag[0], 1'b1);
    wipe(2'b01);
    go(2'b01); waitn(15);
    wipe(2'b01);
    chk("R9", flag[0], 1'b1);
    wipe(2'b01);
    chk("R9", flag[0], 1'b0);

    // R10: independent channels
    cur_req = "R10";
    scale = {2'd1, 2'd1}; tsel = {3'd1, 3'd0};
    go(2'b11); waitn(40);
    chk("R10", flag[0], 1'b1);
    chk("R10", flag[1], 1'b1);
    wipe(2'b01);
    chk("R10", flag[0], 1'b0);
    chk("R10", flag[1], 1'b1);
    wipe(2'b10);
    go(2'b01); waitn(5); fin(2'b10); waitn(11);
    chk("R10", flag[0], 1'b1);
    chk("R10", flag[1], 1'b0);
    wipe(2'b01);

    // R11: stray done, no refire after expiry
    cur_req = "R11";
    fin(2'b11); waitn(50);
    chk("R11", flag[0], 1'b0);
    chk("R11", flag[1], 1'b0);
    go(2'b01); waitn(16);
    chk("R11", flag[0], 1'b1);
    wipe(2'b01); waitn(100);
    chk("R11", flag[0], 1'b0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule